// File: doc/BRIEF.md
# Serial Peripheral Master Engine

This block drives a four-wire serial link as the clocking side. It moves one frame at a time between a parallel data port and the serial pins. Frames are 8 or 16 bits wide and can go out either end first. The idle level of the serial clock is programmable. A 3-bit divider sets the serial clock to the system clock divided by a power of two, from 2 to 256. Data is presented before the first clock edge of each bit cell. The incoming line is sampled on that first edge, and the outgoing line advances on the second edge.

There are two ways to run it. In full-duplex operation, a frame starts whenever a word is waiting in the one-entry transmit holding register. In receive-only operation, the engine clocks frames on its own, and whatever is in the transmit register is left untouched. The chip select comes from one of two places: hardware drives it low for the duration of each frame, or software forces it to a fixed level. A serial checksum with a programmable polynomial runs over the data bits that carry the payload. On request, that checksum is sent as one extra frame. The width, order, polarity and divide settings are captured only while the engine is disabled.

The control sequence has four states. ST_IDLE waits for a start condition and loads the shift register; it moves to ST_LEAD. ST_LEAD holds the clock at its idle level for half a bit cell; on the divider tick it makes the leading edge, samples the input line and moves to ST_TRAIL. ST_TRAIL holds the active level; on the tick it makes the trailing edge and goes back to ST_LEAD, or moves to ST_DONE after the last bit. ST_DONE writes the received word to the receive register and returns to ST_IDLE. Clearing the enable sends every state back to ST_IDLE.

Top module: `spi_master_ctl`

## Requirements
- R1: Each half of a serial clock period lasts 2^psc system clocks, so the leading edges inside a frame are 2^(psc+1) clocks apart (psc 0 gives /2, psc 7 gives /256).
- R2: cfg_wide=0 selects 8-bit frames using data bits [7:0]; cfg_wide=1 selects 16-bit frames. Received words are zero-extended on rx_data.
- R3: cfg_lsb_first=0 puts the most significant bit on the wire first; cfg_lsb_first=1 puts bit 0 first. Received bits are assembled in the same order.
- R4: While no bit cell is active, sck equals the captured polarity bit (0 gives low, 1 gives high); the leading edge moves sck away from that level.
- R5: With rx_only=1, frames are clocked without any transmit word. mosi stays low during data frames, and a word held in the transmit register stays held (tx_empty remains 0).
- R6: With sw_cs_en=0, cs_n is low during every bit cell. With sw_cs_en=1, cs_n equals sw_cs_lvl at all times.
- R7: A frame does not start while rx_full is 1, and rx_data holds its value until it is taken with rx_valid and rx_ready.
- R8: While en=0, busy is low and sck sits at its idle level. Clearing en in the middle of a frame abandons that frame without delivering a received word.
- R9: The checksum is cleared while en=0. For each data bit, in wire order, fb = bit XOR crc[top], then crc = (crc<<1) XOR (fb ? poly : 0), truncated to the frame width. In full-duplex mode, a crc_next pulse makes the frame after the last held word carry this checksum, calculated over the bits sent on mosi.
- R10: In receive-only mode, the checksum runs over the bits sampled on miso. A crc_next pulse given after the second-to-last word is received allows exactly one more data frame, then one frame carrying the checksum on mosi. Clocking then stops until en is cleared.
- R11: cfg_wide, cfg_lsb_first, cfg_cpol and cfg_psc are captured only while en=0. Changes while enabled have no effect until the next enable.
- R12: busy rises when a frame is loaded and falls after the trailing edge of its last bit. mosi is stable between a leading edge and the following trailing edge.
- R13: tx_ready and tx_empty are high exactly when the transmit holding register is free. A word is taken when tx_valid and tx_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Engine enable |
| cfg_wide | input | 1 | Frame width select, 0 = 8 bits, 1 = 16 bits |
| cfg_lsb_first | input | 1 | Bit order, 1 = bit 0 first |
| cfg_cpol | input | 1 | Idle level of sck |
| cfg_psc | input | 3 | Divider exponent, clock / 2^(psc+1) |
| rx_only | input | 1 | 1 = receive-only clocking |
| sw_cs_en | input | 1 | 1 = chip select forced by software |
| sw_cs_lvl | input | 1 | Forced chip select level |
| crc_poly | input | 16 | Checksum polynomial (low 8 bits used for 8-bit frames) |
| crc_next | input | 1 | Pulse requesting a checksum frame |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | 16 | Transmit word |
| tx_ready | output | 1 | Transmit holding register can accept |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Received word taken |
| rx_data | output | 16 | Received word |
| tx_empty | output | 1 | Transmit holding register free |
| rx_full | output | 1 | Receive register occupied |
| busy | output | 1 | Frame bit cells in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
The assertions assume three things about the inputs. First, crc_next arrives only as single-cycle pulses. Second, the configuration inputs are treated as frozen only through the captured copy, never through the pins. Third, miso changes only away from the leading edge. The bench keeps to these rules. It drives every input a short delay after the rising clock edge and pulses crc_next for exactly one cycle. Its slave model advances miso only on the falling clock edge that follows a leading edge it has observed. Configuration is changed while enabled only in the test that shows such changes are ignored.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2,
        ST_DONE  = 2'd3
    } spi_state_e;

    typedef struct packed {
        logic       wide;
        logic       lsb;
        logic       cpol;
        logic [2:0] psc;
    } spi_cfg_t;
endpackage

// File: rtl/spi_master_clkdiv.sv
module spi_master_clkdiv #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    localparam int CNT_W = (1 << PSC_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'((1 << psc) - 1);
    assign tick  = run && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    // R1: after a tick, no tick again until the half period has elapsed
    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && limit != '0) |=> !tick);
endmodule

// File: rtl/spi_master_crc.sv
module spi_master_crc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic         bit_in,
    input  logic         wide,
    input  logic [W-1:0] poly,
    output logic [W-1:0] crc
);
    localparam int HW = W / 2;

    logic         fb;
    logic [W-1:0] nxt;

    always_comb begin
        fb  = bit_in ^ (wide ? crc[W-1] : crc[HW-1]);
        nxt = (crc << 1) ^ (fb ? poly : '0);
        if (!wide) nxt[W-1:HW] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     crc <= '0;
        else if (clear) crc <= '0;
        else if (step)  crc <= nxt;
    end

    // R9: clearing leaves a zero checksum on the next cycle
    a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (crc == '0));
endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl
    import spi_master_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PSC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cfg_wide,
    input  logic              cfg_lsb_first,
    input  logic              cfg_cpol,
    input  logic [PSC_W-1:0]  cfg_psc,
    input  logic              rx_only,
    input  logic              sw_cs_en,
    input  logic              sw_cs_lvl,
    input  logic [DATA_W-1:0] crc_poly,
    input  logic              crc_next,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    localparam int HW    = DATA_W / 2;
    localparam int BIT_W = $clog2(DATA_W + 1);

    spi_cfg_t          cfg_q;
    spi_state_e        state_q, state_d;
    logic              tick, lead_tick, trail_tick, last_bit, start, load_crc;
    logic              in_run, out_bit;
    logic              tx_full, rx_full_q, crc_pend, ro_last, ro_halt, frame_crc, sck_act;
    logic [DATA_W-1:0] tx_buf, tx_sh, rx_sh, rx_q, crc_val;
    logic [BIT_W-1:0]  bitcnt;

    spi_master_clkdiv #(.PSC_W(PSC_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(in_run), .psc(cfg_q.psc), .tick(tick)
    );

    spi_master_crc #(.W(DATA_W)) u_crc (
        .clk(clk), .rst_n(rst_n), .clear(!en), .step(lead_tick && !frame_crc),
        .bit_in(rx_only ? miso : out_bit), .wide(cfg_q.wide),
        .poly(crc_poly), .crc(crc_val)
    );

    assign in_run     = (state_q == ST_LEAD) || (state_q == ST_TRAIL);
    assign lead_tick  = tick && (state_q == ST_LEAD);
    assign trail_tick = tick && (state_q == ST_TRAIL);
    assign last_bit   = bitcnt == (cfg_q.wide ? BIT_W'(DATA_W - 1) : BIT_W'(HW - 1));
    assign load_crc   = rx_only ? ro_last : !tx_full;
    assign start      = en && (state_q == ST_IDLE) && !rx_full_q &&
                        (rx_only ? !ro_halt : (tx_full || crc_pend));
    assign out_bit    = cfg_q.lsb ? tx_sh[0] : (cfg_q.wide ? tx_sh[DATA_W-1] : tx_sh[HW-1]);

    // configuration capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cfg_q <= '0;
        else if (!en) cfg_q <= '{wide: cfg_wide, lsb: cfg_lsb_first, cpol: cfg_cpol, psc: cfg_psc};
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LEAD;
            ST_LEAD:  if (tick) state_d = ST_TRAIL;
            ST_TRAIL: if (tick) state_d = last_bit ? ST_DONE : ST_LEAD;
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state_q <= ST_IDLE;
        else if (!en) state_q <= ST_IDLE;
        else          state_q <= state_d;
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_full <= 1'b0; tx_buf <= '0; tx_sh <= '0; rx_sh <= '0; rx_q <= '0;
            rx_full_q <= 1'b0; crc_pend <= 1'b0; ro_last <= 1'b0; ro_halt <= 1'b0;
            frame_crc <= 1'b0; sck_act <= 1'b0; bitcnt <= '0;
        end else begin
            if (tx_valid && !tx_full) begin
                tx_full <= 1'b1;
                tx_buf  <= tx_data;
            end
            if (rx_ready && rx_full_q) rx_full_q <= 1'b0;
            if (start) begin
                bitcnt    <= '0;
                rx_sh     <= '0;
                frame_crc <= load_crc;
                tx_sh     <= load_crc ? crc_val : (rx_only ? '0 : tx_buf);
                if (rx_only) begin
                    if (ro_last) begin
                        ro_last <= 1'b0;
                        ro_halt <= 1'b1;
                    end else if (crc_pend) begin
                        ro_last  <= 1'b1;
                        crc_pend <= 1'b0;
                    end
                end else if (load_crc) begin
                    crc_pend <= 1'b0;
                end else begin
                    tx_full <= 1'b0;
                end
            end
            if (lead_tick) begin
                sck_act <= 1'b1;
                rx_sh   <= cfg_q.lsb ? {miso, rx_sh[DATA_W-1:1]} : {rx_sh[DATA_W-2:0], miso};
            end
            if (trail_tick) begin
                sck_act <= 1'b0;
                if (!last_bit) begin
                    bitcnt <= bitcnt + 1'b1;
                    tx_sh  <= cfg_q.lsb ? (tx_sh >> 1) : (tx_sh << 1);
                end
            end
            if (state_q == ST_DONE) begin
                rx_full_q <= 1'b1;
                if (cfg_q.wide)     rx_q <= rx_sh;
                else if (cfg_q.lsb) rx_q <= {{HW{1'b0}}, rx_sh[DATA_W-1:HW]};
                else                rx_q <= {{HW{1'b0}}, rx_sh[HW-1:0]};
            end
            if (crc_next && en) crc_pend <= 1'b1;
            if (!en) begin
                crc_pend <= 1'b0;
                ro_last  <= 1'b0;
                ro_halt  <= 1'b0;
                sck_act  <= 1'b0;
            end
        end
    end

    assign tx_ready = !tx_full;
    assign tx_empty = !tx_full;
    assign rx_valid = rx_full_q;
    assign rx_full  = rx_full_q;
    assign rx_data  = rx_q;
    assign busy     = in_run;
    assign sck      = cfg_q.cpol ^ sck_act;
    assign mosi     = in_run ? out_bit : 1'b0;
    assign cs_n     = sw_cs_en ? sw_cs_lvl : !in_run;

    // R8: disabling ends all bit-cell activity on the next cycle
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);
    // R5: receive-only data frames drive mosi low
    a_r5_ro_mosi_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_only && busy && !frame_crc) |-> !mosi);
    // R6: hardware chip select is low during bit cells
    a_r6_hw_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_cs_en && busy) |-> !cs_n);
    // R7: an untaken received word stays put
    a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready && en) |=> (rx_valid && $stable(rx_data)));
    // R11: captured configuration does not move while enabled
    a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> $stable(cfg_q));
    // R12: mosi holds through the active half of a bit cell
    a_r12_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRAIL && !tick && en) |=> $stable(mosi));
endmodule

// File: tb/spi_master_ctl_tb.sv
module spi_master_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, cfg_wide = 1'b0, cfg_lsb_first = 1'b0, cfg_cpol = 1'b0;
    logic [2:0]  cfg_psc = 3'd0;
    logic        rx_only = 1'b0, sw_cs_en = 1'b0, sw_cs_lvl = 1'b1, crc_next = 1'b0;
    logic [15:0] crc_poly = 16'h0007;
    logic        tx_valid = 1'b0, rx_ready = 1'b1;
    logic [15:0] tx_data = '0;
    logic        tx_ready, rx_valid, tx_empty, rx_full, busy, sck, mosi, miso, cs_n;
    logic [15:0] rx_data;

    int checks = 0, failures = 0, cyc = 0;
    logic [15:0] exp_mosi[$];
    logic [15:0] exp_rx[$];
    logic [15:0] slv_word = 16'h5A5A;
    bit m_wide = 0, m_lsb = 0, m_cpol = 0;
    int m_psc = 0, bitpos = 0, last_lead = 0, frames_seen = 0;
    logic [15:0] acc = '0;
    logic prev_sck = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_master_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_wide(cfg_wide), .cfg_lsb_first(cfg_lsb_first),
        .cfg_cpol(cfg_cpol), .cfg_psc(cfg_psc), .rx_only(rx_only), .sw_cs_en(sw_cs_en),
        .sw_cs_lvl(sw_cs_lvl), .crc_poly(crc_poly), .crc_next(crc_next), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .tx_empty(tx_empty), .rx_full(rx_full), .busy(busy), .sck(sck),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    function automatic int fw();
        return m_wide ? 16 : 8;
    endfunction

    function automatic logic [15:0] fmask();
        return m_wide ? 16'hFFFF : 16'h00FF;
    endfunction

    assign miso = (bitpos >= fw()) ? 1'b0 : (m_lsb ? slv_word[bitpos] : slv_word[fw() - 1 - bitpos]);

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // checksum model built from R9: per bit in wire order
    function automatic logic [15:0] crc_word(input logic [15:0] c, input logic [15:0] w);
        logic [15:0] r = c;
        for (int i = 0; i < fw(); i++) begin
            logic b, fb;
            b  = m_lsb ? w[i] : w[fw() - 1 - i];
            fb = b ^ (m_wide ? r[15] : r[7]);
            r  = (r << 1) ^ (fb ? crc_poly : 16'h0);
            if (!m_wide) r[15:8] = 8'h0;
        end
        return r;
    endfunction

    // serial monitor: frames on mosi, spacing, chip select
    always @(negedge clk) begin
        if (!rst_n || !en) begin
            bitpos = 0;
            acc = '0;
        end else if (sck != prev_sck && sck != m_cpol) begin
            if (!sw_cs_en) chk(cs_n == 1'b0, "R6", "cs_n in bit cell", cs_n, 0);
            if (bitpos > 0) chk(cyc - last_lead == (2 << m_psc), "R1", "lead spacing", cyc - last_lead, 2 << m_psc);
            last_lead = cyc;
            if (m_lsb) acc[bitpos] = mosi;
            else       acc[fw() - 1 - bitpos] = mosi;
            bitpos++;
            if (bitpos == fw()) begin
                frames_seen++;
                if (exp_mosi.size() == 0) chk(0, "R2", "unexpected frame", acc, 0);
                else begin
                    logic [15:0] e;
                    e = exp_mosi.pop_front();
                    chk(acc == e, "R3", "mosi frame", acc, e);
                end
                bitpos = 0;
                acc = '0;
            end
        end
        prev_sck = sck;
    end

    // receive monitor
    always @(negedge clk) begin
        if (rst_n && rx_valid && rx_ready) begin
            if (exp_rx.size() == 0) chk(0, "R7", "unexpected rx word", rx_data, 0);
            else begin
                logic [15:0] e;
                e = exp_rx.pop_front();
                chk(rx_data == e, "R2", "rx word", rx_data, e);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic configure(input bit w, input bit l, input bit p, input int s);
        en = 1'b0;
        cfg_wide = w; cfg_lsb_first = l; cfg_cpol = p; cfg_psc = 3'(s);
        m_wide = w; m_lsb = l; m_cpol = p; m_psc = s;
        step(2);
    endtask

    task automatic push_tx(input logic [15:0] w);
        exp_mosi.push_back(w & fmask());
        exp_rx.push_back(slv_word & fmask());
        step(1);
        while (!tx_ready) step(1);
        tx_valid = 1'b1; tx_data = w;
        step(1);
        tx_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        int n = 0;
        while ((exp_mosi.size() != 0 || exp_rx.size() != 0 || busy) && n < 40000) begin
            step(1);
            n++;
        end
        step(4);
        chk(exp_mosi.size() == 0 && exp_rx.size() == 0, req, "queues drained",
            exp_mosi.size() + exp_rx.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] c;
        step(3);
        rst_n = 1'b1;
        step(2);
        // reset state (R8, R13)
        chk(busy == 0 && sck == 0, "R8", "reset quiet", {busy, sck}, 0);
        chk(tx_ready == 1 && tx_empty == 1 && rx_valid == 0, "R13", "reset flags", {tx_ready, tx_empty, rx_valid}, 3'b110);

        // R2 R12: 8-bit msb-first, /2
        configure(0, 0, 0, 0);
        slv_word = 16'h005A;
        en = 1'b1;
        push_tx(16'h00A5);
        push_tx(16'h003C);
        drain("R2");

        // R3 R4: 16-bit lsb-first, high idle, /8
        configure(1, 1, 1, 2);
        chk(sck == 1'b1, "R4", "idle high while disabled", sck, 1);
        slv_word = 16'hC3A1;
        en = 1'b1;
        push_tx(16'h1234);
        push_tx(16'hBEEF);
        drain("R3");
        chk(sck == 1'b1, "R4", "idle high after frames", sck, 1);

        // R1: slowest divider, 8-bit lsb-first
        configure(0, 1, 0, 7);
        slv_word = 16'h0081;
        en = 1'b1;
        push_tx(16'h0096);
        drain("R1");

        // R6: software chip select
        configure(0, 0, 0, 1);
        sw_cs_en = 1'b1; sw_cs_lvl = 1'b1;
        en = 1'b1;
        push_tx(16'h0011);
        while (!busy) step(1);
        chk(cs_n == 1'b1, "R6", "forced high during frame", cs_n, 1);
        drain("R6");
        sw_cs_lvl = 1'b0;
        step(1);
        chk(cs_n == 1'b0, "R6", "forced low while idle", cs_n, 0);
        sw_cs_en = 1'b0;
        step(1);
        chk(cs_n == 1'b1, "R6", "hardware high while idle", cs_n, 1);

        // R7 R13: receive register full blocks further frames
        rx_ready = 1'b0;
        slv_word = 16'h0077;
        push_tx(16'h0001);
        push_tx(16'h0002);
        step(200);
        chk(busy == 0 && rx_valid == 1, "R7", "stalled on full rx", {busy, rx_valid}, 1);
        chk(tx_ready == 0 && tx_empty == 0, "R13", "second word held", {tx_ready, tx_empty}, 0);
        chk(exp_mosi.size() == 1, "R7", "one frame pending", exp_mosi.size(), 1);
        rx_ready = 1'b1;
        drain("R7");

        // R11: polarity change while enabled is ignored
        cfg_cpol = 1'b1;
        step(3);
        chk(sck == 1'b0, "R11", "idle level frozen", sck, 0);
        push_tx(16'h00F0);
        drain("R11");
        en = 1'b0;
        step(2);
        chk(sck == 1'b1, "R11", "new level after disable", sck, 1);

        // R8: abort mid-frame
        configure(0, 0, 0, 7);
        en = 1'b1;
        step(1);
        tx_valid = 1'b1; tx_data = 16'h0055;
        step(1);
        tx_valid = 1'b0;
        step(700);
        chk(busy == 1'b1, "R8", "frame in progress", busy, 1);
        en = 1'b0;
        step(2);
        chk(busy == 0 && sck == 0, "R8", "aborted quiet", {busy, sck}, 0);
        step(20);
        chk(rx_valid == 1'b0, "R8", "no word from aborted frame", rx_valid, 0);

        // R9: full-duplex checksum frame, 8-bit and 16-bit
        configure(0, 0, 0, 0);
        crc_poly = 16'h0007;
        slv_word = 16'h0033;
        en = 1'b1;
        c = '0;
        c = crc_word(c, 16'h0012);
        c = crc_word(c, 16'h0034);
        push_tx(16'h0012);
        push_tx(16'h0034);
        crc_next = 1'b1;
        step(1);
        crc_next = 1'b0;
        exp_mosi.push_back(c);
        exp_rx.push_back(16'h0033);
        drain("R9");

        configure(1, 1, 0, 1);
        crc_poly = 16'h8005;
        slv_word = 16'h1E2D;
        en = 1'b1;
        c = '0;
        c = crc_word(c, 16'hA1B2);
        push_tx(16'hA1B2);
        crc_next = 1'b1;
        step(1);
        crc_next = 1'b0;
        exp_mosi.push_back(c);
        exp_rx.push_back(16'h1E2D);
        drain("R9");

        // R5 R10: receive-only with checksum ending
        configure(0, 0, 0, 0);
        crc_poly = 16'h0007;
        slv_word = 16'h00C9;
        rx_only = 1'b1;
        tx_valid = 1'b1; tx_data = 16'h00FF;
        step(1);
        tx_valid = 1'b0;
        c = '0;
        for (int i = 0; i < 3; i++) begin
            c = crc_word(c, 16'h00C9);
            exp_mosi.push_back(16'h0000);
            exp_rx.push_back(16'h00C9);
        end
        exp_mosi.push_back(c);
        exp_rx.push_back(16'h00C9);
        rx_ready = 1'b0;
        frames_seen = 0;
        en = 1'b1;
        while (!rx_valid) step(1);
        rx_ready = 1'b1; step(1); rx_ready = 1'b0;
        while (!rx_valid) step(1);
        crc_next = 1'b1; step(1); crc_next = 1'b0;
        rx_ready = 1'b1;
        drain("R10");
        step(300);
        chk(frames_seen == 4 && busy == 0, "R10", "clocking halted after checksum", frames_seen, 4);
        chk(tx_empty == 1'b0, "R5", "transmit word left untouched", tx_empty, 0);
        en = 1'b0;
        rx_only = 1'b0;
        step(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule